// File: doc/BRIEF.md
# Fixed-Head Disk Controller Command Decoder

This block is the processor-facing command decoder of a fixed-head disk controller attached to a 12-bit minicomputer. Each I/O transfer instruction reaches it as a strobe. The strobe carries a device subcode (0, 1 or 2) and a 3-bit pulse field. Several pulse bits may be set in one instruction, and together they form compound operations. The block holds the disk address register, the status register (extension fields and error bits) and the done flag. It also owns the interrupt request.

For each instruction the block returns the new accumulator value and a skip flag in the same cycle. It can also issue a one-cycle start request that names the function, read or write. The transfer engine outside the block reports back with a completion strobe and error bits. The current rotational position comes from an external timer, and the block compares the low bits of the disk address against it. A photocell level is presented in the top status bit whenever status is read.

Top module: `disk_iot_ctrl`

## Requirements
- R1: After reset the disk address, extension fields and error bits are zero, done is set and the interrupt request is low.
- R2: Subcode 0 with pulse bit 0 set clears the disk address, the done flag, the error bits and the interrupt request.
- R3: Subcode 0 with pulse bit 1 or 2 set ORs the accumulator into the disk address (after any clear from pulse bit 0 in the same instruction), returns a zero accumulator and raises startReq for that cycle; startWrite equals pulse bit 2 (pulse 2 alone is a read, pulse 4 is a write).
- R4: Subcode 1 with pulse bit 0 set clears status bits 10:3 (disk extension 10:6, memory extension 5:3) before any load in the same instruction.
- R5: Subcode 1 with pulse bit 1 set returns a zero accumulator and skips exactly when disk address bits 10:0 equal rotPos.
- R6: Subcode 1 with pulse bit 2 set ORs bits 10:3 of the accumulator (already zeroed if pulse bit 1 is set) into status, and returns that accumulator ORed with the status as it was before the instruction: bit 11 photoCell, bits 10:3 extensions, bit 2 data late, bit 1 write lock / missing disk, bit 0 parity.
- R7: Subcode 2 with pulse bit 0 set skips exactly when all three error bits are zero.
- R8: Subcode 2 with pulse bit 1 set and pulse bit 2 clear skips exactly when done is set.
- R9: Subcode 2 with pulse bit 2 set returns the disk address ORed into the accumulator, the accumulator first being zeroed when pulse bit 1 is also set.
- R10: xferDone sets done and the interrupt request, and xferErr ORs into the error bits; both win over a clear in the same cycle.
- R11: acOut, skip and startReq are valid in the cycle of the iotValid strobe. With iotValid low, or with subcode 3, acOut equals acIn, skip and startReq are low and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| iotValid | input | 1 | Instruction strobe, one cycle per instruction |
| iotSub | input | 2 | Device subcode |
| iotPulse | input | 3 | Pulse field; bit 0 weight 1, bit 1 weight 2, bit 2 weight 4 |
| acIn | input | 12 | Accumulator value from the processor |
| rotPos | input | 11 | Current rotational word position |
| photoCell | input | 1 | Photocell level shown in status bit 11 |
| xferDone | input | 1 | Transfer engine completion strobe |
| xferErr | input | 3 | Error bits raised by the transfer engine |
| acOut | output | 12 | Accumulator result of the instruction |
| skip | output | 1 | Skip request for the instruction |
| startReq | output | 1 | Start-transfer request, one cycle |
| startWrite | output | 1 | Function of the start request: 1 write, 0 read |
| irq | output | 1 | Interrupt request |

## Verification
acOut, skip and startReq are combinational from the registered state and the strobe, so they are due in the strobe cycle itself. The bench drives each instruction just after a falling edge and samples 1 ns later, well before the rising edge that commits it. Register effects first appear after that rising edge. The bench therefore observes them through a later instruction that reads the disk address, status, done or error state, or by sampling irq in the following low phase.

// File: rtl/fhd_iot_pkg.sv
`timescale 1ns/1ps
package fhd_iot_pkg;
  localparam int NUM_SUB = 3;   // decoded device subcodes
  localparam int PULSE_W = 3;

  typedef struct packed {
    logic clrState;    // sub 0: clear address, done, errors, irq
    logic loadDa;      // sub 0: OR accumulator into address
    logic startOp;     // sub 0: start request
    logic opWrite;     // sub 0: function is write
    logic clrExt;      // sub 1: clear extension fields
    logic orExt;       // sub 1: OR accumulator extensions into status
    logic acOrStatus;  // sub 1: OR old status into accumulator
    logic skipPos;     // sub 1: skip on position match
    logic skipNoErr;   // sub 2: skip when no error
    logic skipDone;    // sub 2: skip when done
    logic acOrDa;      // sub 2: OR address into accumulator
    logic acClear;     // any: zero the accumulator first
  } iotStrobes_t;
endpackage

// File: rtl/fhd_iot_decode.sv
`timescale 1ns/1ps
module fhd_iot_decode
  import fhd_iot_pkg::*;
#(
  parameter int SUB_W = 2
) (
  input  logic               iotValid,
  input  logic [SUB_W-1:0]   iotSub,
  input  logic [PULSE_W-1:0] iotPulse,
  output iotStrobes_t        strobes
);
  logic [NUM_SUB-1:0] subHit;

  for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
    assign subHit[s] = iotValid && (iotSub == SUB_W'(s));
  end

  always_comb begin
    strobes            = '0;
    strobes.clrState   = subHit[0] & iotPulse[0];
    strobes.loadDa     = subHit[0] & (iotPulse[1] | iotPulse[2]);
    strobes.startOp    = subHit[0] & (iotPulse[1] | iotPulse[2]);
    strobes.opWrite    = subHit[0] & iotPulse[2];
    strobes.clrExt     = subHit[1] & iotPulse[0];
    strobes.skipPos    = subHit[1] & iotPulse[1];
    strobes.orExt      = subHit[1] & iotPulse[2];
    strobes.acOrStatus = subHit[1] & iotPulse[2];
    strobes.skipNoErr  = subHit[2] & iotPulse[0];
    strobes.skipDone   = subHit[2] & iotPulse[1] & ~iotPulse[2];
    strobes.acOrDa     = subHit[2] & iotPulse[2];
    strobes.acClear    = (subHit[0] & (iotPulse[1] | iotPulse[2]))
                       | (subHit[1] & iotPulse[1])
                       | (subHit[2] & iotPulse[1] & iotPulse[2]);
  end
endmodule

// File: rtl/fhd_iot_datapath.sv
`timescale 1ns/1ps
module fhd_iot_datapath
  import fhd_iot_pkg::*;
#(
  parameter int WORD_W = 12,
  parameter int POS_W  = 11,
  parameter int ERR_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  iotStrobes_t       strobes,
  input  logic [WORD_W-1:0] acIn,
  input  logic [POS_W-1:0]  rotPos,
  input  logic              photoCell,
  input  logic              xferDone,
  input  logic [ERR_W-1:0]  xferErr,
  output logic [WORD_W-1:0] acOut,
  output logic              skip,
  output logic              irq
);
  localparam int EXT_W   = WORD_W - 1 - ERR_W;
  localparam int EXT_MSB = WORD_W - 2;

  logic [WORD_W-1:0] diskAddr;
  logic [EXT_W-1:0]  extField;
  logic [ERR_W-1:0]  errBits;
  logic              doneFlag;
  logic              irqFlag;

  logic [WORD_W-1:0] statusView;
  logic [WORD_W-1:0] acBase;
  logic              posHit;

  assign statusView = {photoCell, extField, errBits};
  assign acBase     = strobes.acClear ? '0 : acIn;
  assign posHit     = (diskAddr[POS_W-1:0] == rotPos);

  always_comb begin
    acOut = acBase;
    if (strobes.acOrStatus) acOut = acOut | statusView;
    if (strobes.acOrDa)     acOut = acOut | diskAddr;
    skip = (strobes.skipPos & posHit)
         | (strobes.skipNoErr & ~|errBits)
         | (strobes.skipDone & doneFlag);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      diskAddr <= '0;
      extField <= '0;
      errBits  <= '0;
      doneFlag <= 1'b1;
      irqFlag  <= 1'b0;
    end else begin
      diskAddr <= (strobes.clrState ? '0 : diskAddr)
                | (strobes.loadDa ? acIn : '0);
      extField <= (strobes.clrExt ? '0 : extField)
                | (strobes.orExt ? acBase[EXT_MSB:ERR_W] : '0);
      errBits  <= (strobes.clrState ? '0 : errBits) | xferErr;
      if (xferDone) begin
        doneFlag <= 1'b1;
        irqFlag  <= 1'b1;
      end else if (strobes.clrState) begin
        doneFlag <= 1'b0;
        irqFlag  <= 1'b0;
      end
    end
  end

  assign irq = irqFlag;
endmodule

// File: rtl/disk_iot_ctrl.sv
`timescale 1ns/1ps
module disk_iot_ctrl
  import fhd_iot_pkg::*;
#(
  parameter int WORD_W = 12,
  parameter int POS_W  = 11,
  parameter int ERR_W  = 3,
  parameter int SUB_W  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               iotValid,
  input  logic [SUB_W-1:0]   iotSub,
  input  logic [PULSE_W-1:0] iotPulse,
  input  logic [WORD_W-1:0]  acIn,
  input  logic [POS_W-1:0]   rotPos,
  input  logic               photoCell,
  input  logic               xferDone,
  input  logic [ERR_W-1:0]   xferErr,
  output logic [WORD_W-1:0]  acOut,
  output logic               skip,
  output logic               startReq,
  output logic               startWrite,
  output logic               irq
);
  iotStrobes_t strobes;

  fhd_iot_decode #(.SUB_W(SUB_W)) i_decode (
    .iotValid (iotValid),
    .iotSub   (iotSub),
    .iotPulse (iotPulse),
    .strobes  (strobes)
  );

  fhd_iot_datapath #(.WORD_W(WORD_W), .POS_W(POS_W), .ERR_W(ERR_W)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .acIn      (acIn),
    .rotPos    (rotPos),
    .photoCell (photoCell),
    .xferDone  (xferDone),
    .xferErr   (xferErr),
    .acOut     (acOut),
    .skip      (skip),
    .irq       (irq)
  );

  assign startReq   = strobes.startOp;
  assign startWrite = strobes.opWrite;
endmodule

// File: rtl/disk_iot_ctrl_chk.sv
`timescale 1ns/1ps
module disk_iot_ctrl_chk #(
  parameter int WORD_W = 12,
  parameter int SUB_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              iotValid,
  input logic [SUB_W-1:0]  iotSub,
  input logic [2:0]        iotPulse,
  input logic [WORD_W-1:0] acIn,
  input logic              xferDone,
  input logic [WORD_W-1:0] acOut,
  input logic              skip,
  input logic              startReq,
  input logic              irq
);
  p_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !iotValid |-> (!skip && !startReq && acOut == acIn));

  p_done_irq_r10: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> irq);

  p_clear_irq_r2: assert property (@(posedge clk) disable iff (!rstN)
    (iotValid && iotSub == '0 && iotPulse[0] && !xferDone) |=> !irq);

  p_start_ac_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    startReq |-> acOut == '0);

  p_start_source_r3: assert property (@(posedge clk) disable iff (!rstN)
    startReq |-> (iotValid && iotSub == '0 && (iotPulse[1] || iotPulse[2])));
endmodule

bind disk_iot_ctrl disk_iot_ctrl_chk #(.WORD_W(WORD_W), .SUB_W(SUB_W)) i_chk (
  .clk(clk), .rstN(rstN), .iotValid(iotValid), .iotSub(iotSub),
  .iotPulse(iotPulse), .acIn(acIn), .xferDone(xferDone), .acOut(acOut),
  .skip(skip), .startReq(startReq), .irq(irq)
);

// File: tb/test_disk_iot_ctrl.sv
`timescale 1ns/1ps
module test_disk_iot_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        iotValid = 1'b0;
  logic [1:0]  iotSub = '0;
  logic [2:0]  iotPulse = '0;
  logic [11:0] acIn = '0;
  logic [10:0] rotPos = '0;
  logic        photoCell = 1'b0;
  logic        xferDone = 1'b0;
  logic [2:0]  xferErr = '0;
  logic [11:0] acOut;
  logic        skip, startReq, startWrite, irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  disk_iot_ctrl i_disk_iot_ctrl (
    .clk(clk), .rstN(rstN), .iotValid(iotValid), .iotSub(iotSub),
    .iotPulse(iotPulse), .acIn(acIn), .rotPos(rotPos), .photoCell(photoCell),
    .xferDone(xferDone), .xferErr(xferErr), .acOut(acOut), .skip(skip),
    .startReq(startReq), .startWrite(startWrite), .irq(irq)
  );

  // {req(4), sub(2), pulse(3), ac(12), pos(11), photo(1), expAc(12), expSkip, expStart, expWrite}
  localparam int NV = 19;
  localparam logic [47:0] VEC [NV] = '{
    {4'd8, 2'd2, 3'o2, 12'o1234, 11'o0,    1'b0, 12'o1234, 1'b1, 1'b0, 1'b0}, // R8 done after reset
    {4'd9, 2'd2, 3'o4, 12'o0001, 11'o0,    1'b0, 12'o0001, 1'b0, 1'b0, 1'b0}, // R9 address zero
    {4'd3, 2'd0, 3'o3, 12'o0500, 11'o0,    1'b0, 12'o0000, 1'b0, 1'b1, 1'b0}, // R3 clear+read
    {4'd2, 2'd2, 3'o2, 12'o0000, 11'o0,    1'b0, 12'o0000, 1'b0, 1'b0, 1'b0}, // R2 done cleared
    {4'd9, 2'd2, 3'o6, 12'o7777, 11'o0,    1'b0, 12'o0500, 1'b0, 1'b0, 1'b0}, // R9 clear+load
    {4'd3, 2'd0, 3'o4, 12'o0022, 11'o0,    1'b0, 12'o0000, 1'b0, 1'b1, 1'b1}, // R3 write, OR
    {4'd5, 2'd1, 3'o2, 12'o0777, 11'o0522, 1'b0, 12'o0000, 1'b1, 1'b0, 1'b0}, // R5 match
    {4'd5, 2'd1, 3'o2, 12'o0777, 11'o0523, 1'b0, 12'o0000, 1'b0, 1'b0, 1'b0}, // R5 mismatch
    {4'd6, 2'd1, 3'o4, 12'o7777, 11'o0,    1'b0, 12'o7777, 1'b0, 1'b0, 1'b0}, // R6 old status 0
    {4'd6, 2'd1, 3'o4, 12'o0000, 11'o0,    1'b1, 12'o7770, 1'b0, 1'b0, 1'b0}, // R6 photocell
    {4'd4, 2'd1, 3'o1, 12'o0000, 11'o0,    1'b0, 12'o0000, 1'b0, 1'b0, 1'b0}, // R4 clear ext
    {4'd6, 2'd1, 3'o4, 12'o0050, 11'o0,    1'b0, 12'o0050, 1'b0, 1'b0, 1'b0}, // R6 after clear
    {4'd4, 2'd1, 3'o5, 12'o0200, 11'o0,    1'b0, 12'o0250, 1'b0, 1'b0, 1'b0}, // R4 clear then load
    {4'd6, 2'd1, 3'o4, 12'o0000, 11'o0,    1'b0, 12'o0200, 1'b0, 1'b0, 1'b0}, // R6 read back
    {4'd5, 2'd1, 3'o6, 12'o3700, 11'o0,    1'b0, 12'o0200, 1'b0, 1'b0, 1'b0}, // R5 zeroed ac
    {4'd6, 2'd1, 3'o4, 12'o0000, 11'o0,    1'b0, 12'o0200, 1'b0, 1'b0, 1'b0}, // R6 no 3700 loaded
    {4'd7, 2'd2, 3'o1, 12'o0000, 11'o0,    1'b0, 12'o0000, 1'b1, 1'b0, 1'b0}, // R7 no error
    {4'd11,2'd3, 3'o7, 12'o1111, 11'o0,    1'b0, 12'o1111, 1'b0, 1'b0, 1'b0}, // R11 subcode 3
    {4'd11,2'd2, 3'o4, 12'o0000, 11'o0,    1'b0, 12'o0522, 1'b0, 1'b0, 1'b0}  // R11 address kept
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0o expected %0o", tag, act, exp);
    end
  endtask

  // drive one instruction after a falling edge, leave it for the next rising edge
  task automatic iot(input logic [1:0] s, input logic [2:0] p, input logic [11:0] a,
                     input logic [10:0] pos, input logic ph);
    @(negedge clk);
    iotValid = 1'b1; iotSub = s; iotPulse = p; acIn = a; rotPos = pos; photoCell = ph;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    iotValid = 1'b0; xferDone = 1'b0; xferErr = '0; acIn = '0;
    #1;
  endtask

  initial begin
    #800000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    chk("R1 irq after reset", irq, 0);

    for (int i = 0; i < NV; i++) begin
      logic [47:0] v;
      v = VEC[i];
      iot(v[43:42], v[41:39], v[38:27], v[26:16], v[15]);
      chk($sformatf("R%0d vec%0d acOut", v[47:44], i), acOut, v[14:3]);
      chk($sformatf("R%0d vec%0d skip", v[47:44], i), skip, v[2]);
      chk($sformatf("R%0d vec%0d startReq", v[47:44], i), startReq, v[1]);
      if (v[1]) chk($sformatf("R%0d vec%0d startWrite", v[47:44], i), startWrite, v[0]);
    end

    // R11: no strobe, accumulator passes through
    idle();
    acIn = 12'o4321; #1;
    chk("R11 quiet acOut", acOut, 12'o4321);
    chk("R11 quiet skip", skip, 0);
    chk("R11 quiet startReq", startReq, 0);

    // R10: completion with data late error
    @(negedge clk); xferDone = 1'b1; xferErr = 3'b100;
    idle();
    chk("R10 irq set", irq, 1);
    iot(2'd2, 3'o1, 12'o0, 11'o0, 1'b0);
    chk("R7 skip with error", skip, 0);
    iot(2'd2, 3'o2, 12'o0, 11'o0, 1'b0);
    chk("R10 done set", skip, 1);
    iot(2'd1, 3'o4, 12'o0, 11'o0, 1'b0);
    chk("R6 status shows error", acOut, 12'o0204);

    // R10: completion beats same-cycle clear
    iot(2'd0, 3'o1, 12'o0, 11'o0, 1'b0);
    xferDone = 1'b1;
    chk("R2 clear alone starts nothing", startReq, 0);
    idle();
    chk("R10 irq wins over clear", irq, 1);
    iot(2'd2, 3'o2, 12'o0, 11'o0, 1'b0);
    chk("R10 done wins over clear", skip, 1);
    iot(2'd2, 3'o1, 12'o0, 11'o0, 1'b0);
    chk("R2 errors cleared", skip, 1);
    iot(2'd2, 3'o4, 12'o0, 11'o0, 1'b0);
    chk("R2 address cleared", acOut, 12'o0);

    // R2: plain clear
    iot(2'd0, 3'o1, 12'o0, 11'o0, 1'b0);
    idle();
    chk("R2 irq cleared", irq, 0);
    iot(2'd2, 3'o2, 12'o0, 11'o0, 1'b0);
    chk("R2 done cleared", skip, 0);

    // R1: reset in the middle of a run
    iot(2'd0, 3'o2, 12'o0123, 11'o0, 1'b0);
    iot(2'd1, 3'o4, 12'o3770, 11'o0, 1'b0);
    @(negedge clk); iotValid = 1'b0; xferDone = 1'b1; xferErr = 3'b011;
    @(negedge clk); xferDone = 1'b0; xferErr = '0; rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    #1;
    chk("R1 irq reset", irq, 0);
    iot(2'd2, 3'o2, 12'o0, 11'o0, 1'b0);
    chk("R1 done reset", skip, 1);
    iot(2'd2, 3'o1, 12'o0, 11'o0, 1'b0);
    chk("R1 errors reset", skip, 1);
    iot(2'd1, 3'o4, 12'o0, 11'o0, 1'b0);
    chk("R1 status reset", acOut, 12'o0);
    iot(2'd2, 3'o4, 12'o0, 11'o0, 1'b0);
    chk("R1 address reset", acOut, 12'o0);
    idle();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule